// File: doc/BRIEF.md
# Command Block Mailbox Register Interface

This block is the host-facing register file of a disk controller that takes its commands as parameter blocks placed in memory. The host builds a 32-bit block address one byte at a time and adds an address-modifier byte. It then raises an add request through the control/status register (CSR). The controller side sees the pending address on a valid/take handshake and accepts it by pulsing a take strobe.

When a command finishes, the controller pushes the address of the completed block into a small internal queue. The block posts queued addresses one at a time into the shared address registers and raises a remove flag, which the host acknowledges through the CSR.

The CSR also carries several other bits:
- a busy indication
- a sticky fatal-error flag, whose code sits in its own register
- a soft reset
- a maintenance-mode bit
- a register semaphore bit

Top module: `cmdblk_mailbox`

## Requirements
- R1: After hardware reset, with the controller idle, every host register reads 0x00, `add_valid` is 0 and `done_ready` is 1.
- R2: Host byte offsets select the registers as follows:
  - 1, 3, 5 and 7 hold address bits [7:0], [15:8], [23:16] and [31:24].
  - 9 holds the address modifier.
  - 11 is the CSR.
  - 13 is the fatal error code.
  - Every other offset reads 0x00 and ignores writes.
  - Host writes to offset 13 have no effect.
- R3: CSR bit 5 (maintenance) and bit 0 (semaphore) read back what was last written to them. A written bit 7 does not change the bit 7 read value. Bit 4 always reads 0.
- R4: Writing CSR bit 2 = 1 sets add-pending. Add-pending reads as CSR bit 2 and drives `add_valid`, with `add_addr` and `add_mod` equal to the address and modifier registers. It stays set until `add_take` is seen while it is set.
- R5: While add-pending is set, host writes to the address and modifier registers are ignored.
- R6: A completed address accepted on `done_valid`/`done_ready` is posted into the address registers and CSR bit 1 reads 1. Posting happens when no remove is pending, no add is pending, soft reset is off and no host write is in that cycle. Writing CSR bit 1 = 1 clears the remove flag. Completions are posted one at a time in arrival order.
- R7: No completion is posted while an add is pending; the host's address stays visible until the add is taken.
- R8: Up to QDEPTH completions wait in the queue behind the posted one. `done_ready` is 0 while the queue is full, and a `done_valid` then is dropped.
- R9: A `fatal_valid` pulse loads `fatal_code` into offset 13 and sets CSR bit 6. Both persist until soft reset.
- R10: Writing CSR bit 3 = 1 starts a soft reset, in the same cycle clearing:
  - add-pending and remove-pending
  - the fatal flag and fatal code
  - the queue

  While bit 3 is set, CSR bit 7 reads 1. After bit 3 is written back to 0, bit 7 reads 1 for exactly BUSY_HOLD more cycles.
- R11: CSR bit 7 reads 1 whenever the `ctl_busy` input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 4 | Host byte offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for `hst_addr` |
| add_valid | output | 1 | A submitted block address is pending |
| add_addr | output | 32 | Pending block address |
| add_mod | output | 8 | Pending address modifier |
| add_take | input | 1 | Controller accepts the pending address |
| done_valid | input | 1 | Controller offers a completed block address |
| done_addr | input | 32 | Completed block address |
| done_ready | output | 1 | Completion queue can accept |
| ctl_busy | input | 1 | Controller busy |
| fatal_valid | input | 1 | Load a fatal error code |
| fatal_code | input | 8 | Fatal error code |

## Verification
The hardest state to reach from the ports is a full completion queue while a remove is already posted. The bench gets there by pushing one completion and letting it post. It then keeps pushing without ever clearing the remove flag until `done_ready` drops, and offers one more completion that must be lost. Draining then clears the flag repeatedly and checks that the queued addresses come out in order. A further scenario holds an add pending while a completion arrives, so that posting must wait on the take strobe.

// File: rtl/cmdblk_mailbox.sv
module cmdblk_mailbox #(
  parameter int QDEPTH    = 31,
  parameter int BUSY_HOLD = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_wr,
  input  logic [3:0]  hst_addr,
  input  logic [7:0]  hst_wdata,
  output logic [7:0]  hst_rdata,
  output logic        add_valid,
  output logic [31:0] add_addr,
  output logic [7:0]  add_mod,
  input  logic        add_take,
  input  logic        done_valid,
  input  logic [31:0] done_addr,
  output logic        done_ready,
  input  logic        ctl_busy,
  input  logic        fatal_valid,
  input  logic [7:0]  fatal_code
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int HW = (BUSY_HOLD > 1) ? $clog2(BUSY_HOLD + 1) : 1;

  logic [31:0] ptr_q;
  logic [7:0]  mod_q, err_q;
  logic        add_pend, rem_pend, fatal_q, srst_q, maint_q, sem_q;
  logic [HW-1:0] hold_q;
  logic [31:0] q_mem [QDEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire wr_csr = hst_wr && (hst_addr == 4'd11);
  wire clr    = srst_q || (wr_csr && hst_wdata[3]);
  wire push   = done_valid && done_ready;
  wire pop    = (cnt != '0) && !rem_pend && !add_pend && !srst_q && !hst_wr;
  wire busy   = ctl_busy || srst_q || (hold_q != '0);

  assign done_ready = !srst_q && (cnt != CW'(QDEPTH));
  assign add_valid  = add_pend;
  assign add_addr   = ptr_q;
  assign add_mod    = mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      mod_q <= '0;
    end else if (pop) begin
      ptr_q <= q_mem[rp];
    end else if (hst_wr && !add_pend) begin
      case (hst_addr)
        4'd1: ptr_q[7:0]   <= hst_wdata;
        4'd3: ptr_q[15:8]  <= hst_wdata;
        4'd5: ptr_q[23:16] <= hst_wdata;
        4'd7: ptr_q[31:24] <= hst_wdata;
        4'd9: mod_q        <= hst_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      maint_q <= 1'b0;
      sem_q   <= 1'b0;
    end else if (wr_csr) begin
      srst_q  <= hst_wdata[3];
      maint_q <= hst_wdata[5];
      sem_q   <= hst_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_pend <= 1'b0;
      rem_pend <= 1'b0;
      fatal_q  <= 1'b0;
      err_q    <= '0;
    end else if (clr) begin
      add_pend <= 1'b0;
      rem_pend <= 1'b0;
      fatal_q  <= 1'b0;
      err_q    <= '0;
    end else begin
      if (add_pend && add_take)         add_pend <= 1'b0;
      else if (wr_csr && hst_wdata[2])  add_pend <= 1'b1;
      if (pop)                          rem_pend <= 1'b1;
      else if (wr_csr && hst_wdata[1])  rem_pend <= 1'b0;
      if (fatal_valid) begin
        fatal_q <= 1'b1;
        err_q   <= fatal_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (srst_q)         hold_q <= HW'(BUSY_HOLD);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) q_mem[wp] <= done_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(QDEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(QDEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (hst_addr)
      4'd1:    hst_rdata = ptr_q[7:0];
      4'd3:    hst_rdata = ptr_q[15:8];
      4'd5:    hst_rdata = ptr_q[23:16];
      4'd7:    hst_rdata = ptr_q[31:24];
      4'd9:    hst_rdata = mod_q;
      4'd11:   hst_rdata = {busy, fatal_q, maint_q, 1'b0, srst_q, add_pend, rem_pend, sem_q};
      4'd13:   hst_rdata = err_q;
      default: hst_rdata = 8'h00;
    endcase
  end

  // R4
  add_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_pend && !add_take && !clr |=> add_pend);

  // R6
  post_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_pend && !hst_wr |=> $stable(ptr_q));

  // R7
  post_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rem_pend) |-> $past(!add_pend));

  // R8
  q_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !clr |=> cnt != '0 || rem_pend);

  // R9
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_q && !clr |=> fatal_q);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_q) |-> (busy || BUSY_HOLD == 0));
endmodule

// File: tb/tb_cmdblk_mailbox.sv
`timescale 1ns/1ps
module tb_cmdblk_mailbox;
  localparam int QD = 31;
  localparam int BH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 1'b0;
  logic [3:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0, hst_rdata;
  logic add_valid, add_take = 1'b0, done_valid = 1'b0, done_ready;
  logic [31:0] add_addr, done_addr = '0;
  logic [7:0] add_mod, fatal_code = '0;
  logic ctl_busy = 1'b0, fatal_valid = 1'b0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  cmdblk_mailbox #(.QDEPTH(QD), .BUSY_HOLD(BH)) dut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .add_valid(add_valid),
    .add_addr(add_addr), .add_mod(add_mod), .add_take(add_take),
    .done_valid(done_valid), .done_addr(done_addr), .done_ready(done_ready),
    .ctl_busy(ctl_busy), .fatal_valid(fatal_valid), .fatal_code(fatal_code));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    hst_addr = a;
    #1;
    d = hst_rdata;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    rd(4'd1, b0); rd(4'd3, b1); rd(4'd5, b2); rd(4'd7, b3);
    v = {b3, b2, b1, b0};
  endtask

  task automatic wr32(input logic [31:0] v);
    wr(4'd1, v[7:0]); wr(4'd3, v[15:8]); wr(4'd5, v[23:16]); wr(4'd7, v[31:24]);
  endtask

  task automatic push(input logic [31:0] a);
    @(negedge clk);
    done_valid = 1'b1; done_addr = a;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    add_take = 1'b1;
    @(negedge clk);
    add_take = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reg after reset", {24'h0, d}, 32'h0);
    end
    chk("R1 add_valid", {31'h0, add_valid}, 32'h0);
    chk("R1 done_ready", {31'h0, done_ready}, 32'h1);
  endtask

  task automatic t_regmap();
    logic [31:0] v; logic [7:0] d;
    wr32(32'h44332211);
    wr(4'd9, 8'h3D);
    wr(4'd2, 8'hAA);
    wr(4'd13, 8'h5A);
    rd32(v); chk("R2 address bytes", v, 32'h44332211);
    rd(4'd9, d); chk("R2 modifier", {24'h0, d}, 32'h3D);
    rd(4'd2, d); chk("R2 even offset", {24'h0, d}, 32'h0);
    rd(4'd13, d); chk("R2 error reg write ignored", {24'h0, d}, 32'h0);
  endtask

  task automatic t_csr_bits();
    logic [7:0] d;
    wr(4'd11, 8'hB1);
    rd(4'd11, d); chk("R3 csr rw bits, bit7 write ignored", {24'h0, d}, 32'h21);
    ctl_busy = 1'b1;
    rd(4'd11, d); chk("R11 busy input", {24'h0, d}, 32'hA1);
    ctl_busy = 1'b0;
    wr(4'd11, 8'h00);
    rd(4'd11, d); chk("R3 csr cleared", {24'h0, d}, 32'h0);
  endtask

  task automatic t_add();
    logic [7:0] d;
    wr32(32'hCAFE0100);
    wr(4'd9, 8'h0D);
    wr(4'd11, 8'h04);
    rd(4'd11, d); chk("R4 add pending bit", {24'h0, d}, 32'h04);
    chk("R4 add_valid", {31'h0, add_valid}, 32'h1);
    chk("R4 add_addr", add_addr, 32'hCAFE0100);
    chk("R4 add_mod", {24'h0, add_mod}, 32'h0D);
    wr(4'd1, 8'hFF);
    wr(4'd9, 8'h3D);
    chk("R5 addr write ignored", add_addr, 32'hCAFE0100);
    chk("R5 mod write ignored", {24'h0, add_mod}, 32'h0D);
    idle(2);
    chk("R4 add held", {31'h0, add_valid}, 32'h1);
    take();
    rd(4'd11, d); chk("R4 add cleared by take", {24'h0, d}, 32'h0);
  endtask

  task automatic t_complete();
    logic [31:0] v; logic [7:0] d;
    push(32'hA0B0C0D0);
    idle(1);
    rd(4'd11, d); chk("R6 remove bit", {24'h0, d}, 32'h02);
    rd32(v); chk("R6 posted address", v, 32'hA0B0C0D0);
    push(32'h12345678);
    idle(2);
    rd32(v); chk("R6 held while remove pending", v, 32'hA0B0C0D0);
    wr(4'd11, 8'h02);
    idle(1);
    rd32(v); chk("R6 next posted", v, 32'h12345678);
    rd(4'd11, d); chk("R6 remove again", {24'h0, d}, 32'h02);
    wr(4'd11, 8'h02);
    idle(2);
    rd(4'd11, d); chk("R6 remove cleared", {24'h0, d}, 32'h0);
  endtask

  task automatic t_post_gate();
    logic [31:0] v; logic [7:0] d;
    wr32(32'h01020304);
    wr(4'd11, 8'h04);
    push(32'h0BADF00D);
    idle(3);
    rd(4'd11, d); chk("R7 no post while add pending", {24'h0, d}, 32'h04);
    rd32(v); chk("R7 host address kept", v, 32'h01020304);
    take();
    idle(1);
    rd(4'd11, d); chk("R7 posted after take", {24'h0, d}, 32'h02);
    rd32(v); chk("R7 posted address", v, 32'h0BADF00D);
    wr(4'd11, 8'h02);
    idle(2);
  endtask

  task automatic t_queue_full();
    logic [31:0] v; logic [7:0] d;
    @(negedge clk);
    for (int i = 0; i <= QD; i++) begin
      done_valid = 1'b1; done_addr = 32'h5000_0000 + i;
      @(negedge clk);
    end
    done_valid = 1'b0;
    chk("R8 ready low when full", {31'h0, done_ready}, 32'h0);
    done_valid = 1'b1; done_addr = 32'hDEADDEAD;
    @(negedge clk);
    done_valid = 1'b0;
    rd32(v); chk("R8 first posted", v, 32'h5000_0000);
    for (int i = 1; i <= QD; i++) begin
      wr(4'd11, 8'h02);
      idle(1);
      rd32(v); chk("R8 drain order", v, 32'h5000_0000 + i);
    end
    wr(4'd11, 8'h02);
    idle(3);
    rd(4'd11, d); chk("R8 overflow dropped", {24'h0, d}, 32'h0);
    chk("R8 ready again", {31'h0, done_ready}, 32'h1);
  endtask

  task automatic t_fatal();
    logic [7:0] d;
    @(negedge clk);
    fatal_valid = 1'b1; fatal_code = 8'hE5;
    @(negedge clk);
    fatal_valid = 1'b0;
    rd(4'd13, d); chk("R9 fatal code", {24'h0, d}, 32'hE5);
    rd(4'd11, d); chk("R9 fatal bit", {24'h0, d}, 32'h40);
    wr(4'd13, 8'h00);
    idle(2);
    rd(4'd13, d); chk("R9 code sticky", {24'h0, d}, 32'hE5);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    wr(4'd11, 8'h04);
    push(32'h77777777);
    wr(4'd11, 8'h08);
    rd(4'd11, d); chk("R10 csr in soft reset", {24'h0, d}, 32'h88);
    rd(4'd13, d); chk("R10 error code cleared", {24'h0, d}, 32'h0);
    chk("R10 add cleared", {31'h0, add_valid}, 32'h0);
    chk("R10 ready low in reset", {31'h0, done_ready}, 32'h0);
    wr(4'd11, 8'h00);
    rd(4'd11, d); chk("R10 busy after release", {24'h0, d}, 32'h80);
    idle(BH - 1);
    rd(4'd11, d); chk("R10 busy last cycle", {24'h0, d}, 32'h80);
    idle(1);
    rd(4'd11, d); chk("R10 busy ends, queue flushed", {24'h0, d}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_csr_bits();
    t_add();
    t_complete();
    t_post_gate();
    t_queue_full();
    t_fatal();
    t_soft_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule